// File: doc/BRIEF.md
# Grouped GPIO Interrupt Status Aggregator

This block gathers per-pin pending indications from a large bank of GPIO pins and condenses them into a summary vector. Each summary bit stands for one group of four neighbouring pins. A pin counts as pending when its interrupt status or its wake status is set. The summary is presented as two data words. The low word carries the first groups. The high word carries the remaining groups in its lowest positions, and any position that no group uses reads as zero.

A single combined interrupt request goes to the processor. The request rises once any group reports a pending pin and then stays high. A control word written by software carries an end-of-interrupt bit. The service routine scans the summary words, handles the four pins of each set group, and then writes end-of-interrupt. That write drops the request for exactly one cycle. If a source is still pending, the request then rises again as a fresh one. The other bits of the control word are ordinary stored read/write bits. Per-pin edge and level detection happens upstream and is not part of this block.

Top module: `gpio_grp_irq_agg`

## Requirements
- R1: One clock edge after the pin inputs are sampled, summary bit g equals the OR of the pending flags of pins GROUP_SIZE*g up to GROUP_SIZE*g+GROUP_SIZE-1; with no pin pending, the summary is all zero.
- R2: A pin is pending when its interrupt status input or its wake status input is 1; either input alone sets the group's summary bit.
- R3: summary_lo bit k carries summary bit k for k below WORD_W; summary_hi bit k carries summary bit WORD_W+k; summary_hi positions at or above NUM_GROUPS-WORD_W read as 0.
- R4: While irq_out is low and no end-of-interrupt is written, a nonzero summary raises irq_out at the next clock edge.
- R5: Once high, irq_out stays high until an end-of-interrupt write, even if every pin stops being pending.
- R6: A control write with bit EOI_POS (default 29) set to 1 is an end-of-interrupt, and irq_out is low after that clock edge. A control write with that bit set to 0 leaves irq_out unchanged.
- R7: If the summary is still nonzero after an end-of-interrupt, irq_out rises again one clock edge later, giving exactly one low cycle.
- R8: A control write stores every bit of the write data except bit EOI_POS, and the stored value appears on ctl_rd_data after the edge. Bit EOI_POS always reads 0.
- R9: After reset, both summary words, ctl_rd_data and irq_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_int_sts | input | GROUP_SIZE*NUM_GROUPS (184) | Per-pin interrupt status flags |
| pin_wake_sts | input | GROUP_SIZE*NUM_GROUPS (184) | Per-pin wake status flags |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | WORD_W (32) | Control word write data; bit EOI_POS is end-of-interrupt |
| ctl_rd_data | output | WORD_W (32) | Stored control word, end-of-interrupt bit always 0 |
| summary_lo | output | WORD_W (32) | Group summary, lower word |
| summary_hi | output | WORD_W (32) | Group summary, upper word, unused positions 0 |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with 10 groups of 4 pins, 8-bit words and the end-of-interrupt bit at position 5. With that configuration all 40 pins can be swept one at a time through both status inputs. The setup also puts two groups into the high word and leaves six unused high-word positions whose zero padding can be observed. The small word width lets the control register be checked with patterns that both set and clear the end-of-interrupt bit. Sustained and removed pending sources around end-of-interrupt writes show the hold, drop and re-request behaviour of the interrupt line.

// File: rtl/gia_pkg.sv
`timescale 1ns/1ps
package gia_pkg;
   localparam int GIA_GROUP_SIZE = 4;
   localparam int GIA_NUM_GROUPS = 46;
   localparam int GIA_WORD_W     = 32;
   localparam int GIA_EOI_POS    = 29;

   // number of summary words needed for a group count
   function automatic int words_for(input int groups, input int word_w);
      return (groups + word_w - 1) / word_w;
   endfunction
endpackage

// File: rtl/gia_group_reduce.sv
`timescale 1ns/1ps
module gia_group_reduce #(
   parameter int GROUP_SIZE = gia_pkg::GIA_GROUP_SIZE,
   parameter int NUM_GROUPS = gia_pkg::GIA_NUM_GROUPS
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [GROUP_SIZE*NUM_GROUPS-1:0] int_sts,
   input  logic [GROUP_SIZE*NUM_GROUPS-1:0] wake_sts,
   output logic [NUM_GROUPS-1:0]            sum_q
);
   localparam int NUM_PINS = GROUP_SIZE * NUM_GROUPS;

   logic [NUM_PINS-1:0]   pend;
   logic [NUM_GROUPS-1:0] grp_hit;

   assign pend = int_sts | wake_sts;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      assign grp_hit[g] = |pend[g*GROUP_SIZE +: GROUP_SIZE];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sum_q <= '0;
      else        sum_q <= grp_hit;
   end

   // R1: quiet pins give an empty summary one edge later
   assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pend) == '0) |-> (sum_q == '0));

   // R2: a wake flag alone marks its group
   assert_wake_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wake_sts[GROUP_SIZE-1]) |-> sum_q[0]);
endmodule

// File: rtl/gia_word_split.sv
`timescale 1ns/1ps
module gia_word_split #(
   parameter int NUM_GROUPS = gia_pkg::GIA_NUM_GROUPS,
   parameter int WORD_W     = gia_pkg::GIA_WORD_W
) (
   input  logic [NUM_GROUPS-1:0] sum_in,
   output logic [WORD_W-1:0]     word_lo,
   output logic [WORD_W-1:0]     word_hi
);
   localparam int SUM_W = 2 * WORD_W;

   logic [SUM_W-1:0] wide;

   if (NUM_GROUPS == SUM_W) begin : g_full
      assign wide = sum_in;
   end else begin : g_pad
      assign wide = {{(SUM_W-NUM_GROUPS){1'b0}}, sum_in};
   end

   assign word_lo = wide[WORD_W-1:0];
   assign word_hi = wide[SUM_W-1:WORD_W];
endmodule

// File: rtl/gia_master_reg.sv
`timescale 1ns/1ps
module gia_master_reg #(
   parameter int WORD_W  = gia_pkg::GIA_WORD_W,
   parameter int EOI_POS = gia_pkg::GIA_EOI_POS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] rd_data,
   output logic              eoi_pulse
);
   localparam logic [WORD_W-1:0] EOI_MASK = WORD_W'(1) << EOI_POS;

   logic [WORD_W-1:0] ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctl_q <= '0;
      else if (wr_en) ctl_q <= wr_data & ~EOI_MASK;
   end

   assign rd_data   = ctl_q;
   assign eoi_pulse = wr_en & wr_data[EOI_POS];

   // R8: written value is kept, the self-clearing bit excepted
   assert_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data == ($past(wr_data) & ~EOI_MASK)));
endmodule

// File: rtl/gia_irq_gate.sv
`timescale 1ns/1ps
module gia_irq_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic any_pending,
   input  logic eoi,
   output logic irq
);
   logic irq_q;

   // the request itself acts as the disarm state; EOI re-arms it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   irq_q <= 1'b0;
      else if (eoi) irq_q <= 1'b0;
      else          irq_q <= irq_q | any_pending;
   end

   assign irq = irq_q;

   assert_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && any_pending && !eoi) |=> irq);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !eoi) |=> irq);

   assert_eoi_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      eoi |=> !irq);

   assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(eoi) && any_pending && !eoi) |=> irq);
endmodule

// File: rtl/gpio_grp_irq_agg.sv
`timescale 1ns/1ps
module gpio_grp_irq_agg #(
   parameter int GROUP_SIZE = gia_pkg::GIA_GROUP_SIZE,
   parameter int NUM_GROUPS = gia_pkg::GIA_NUM_GROUPS,
   parameter int WORD_W     = gia_pkg::GIA_WORD_W,
   parameter int EOI_POS    = gia_pkg::GIA_EOI_POS
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [GROUP_SIZE*NUM_GROUPS-1:0] pin_int_sts,
   input  logic [GROUP_SIZE*NUM_GROUPS-1:0] pin_wake_sts,
   input  logic                             ctl_wr_en,
   input  logic [WORD_W-1:0]                ctl_wr_data,
   output logic [WORD_W-1:0]                ctl_rd_data,
   output logic [WORD_W-1:0]                summary_lo,
   output logic [WORD_W-1:0]                summary_hi,
   output logic                             irq_out
);
   localparam int NUM_WORDS = gia_pkg::words_for(NUM_GROUPS, WORD_W);

   if (GROUP_SIZE < 1) begin : g_bad_group
      $error("GROUP_SIZE must be at least 1");
   end
   if (NUM_WORDS > 2 || NUM_GROUPS < 1) begin : g_bad_groups
      $error("NUM_GROUPS must fit in two summary words");
   end
   if (EOI_POS < 0 || EOI_POS >= WORD_W) begin : g_bad_eoi
      $error("EOI_POS must lie inside the control word");
   end

   logic [NUM_GROUPS-1:0] sum_q;
   logic                  eoi_pulse;

   gia_group_reduce #(.GROUP_SIZE(GROUP_SIZE), .NUM_GROUPS(NUM_GROUPS)) u_reduce (
      .clk      (clk),
      .rst_n    (rst_n),
      .int_sts  (pin_int_sts),
      .wake_sts (pin_wake_sts),
      .sum_q    (sum_q)
   );

   gia_word_split #(.NUM_GROUPS(NUM_GROUPS), .WORD_W(WORD_W)) u_split (
      .sum_in  (sum_q),
      .word_lo (summary_lo),
      .word_hi (summary_hi)
   );

   gia_master_reg #(.WORD_W(WORD_W), .EOI_POS(EOI_POS)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (ctl_wr_en),
      .wr_data   (ctl_wr_data),
      .rd_data   (ctl_rd_data),
      .eoi_pulse (eoi_pulse)
   );

   gia_irq_gate u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .any_pending (|sum_q),
      .eoi         (eoi_pulse),
      .irq         (irq_out)
   );
endmodule

// File: tb/gpio_grp_irq_agg_bench.sv
`timescale 1ns/1ps
module gpio_grp_irq_agg_bench;
   localparam int GS = 4;
   localparam int NG = 10;
   localparam int WW = 8;
   localparam int EP = 5;
   localparam int NP = GS * NG;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] int_v = '0;
   logic [NP-1:0] wake_v = '0;
   logic          wr_en = 1'b0;
   logic [WW-1:0] wr_data = '0;
   logic [WW-1:0] rd_data;
   logic [WW-1:0] s_lo;
   logic [WW-1:0] s_hi;
   logic          irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2 clk = ~clk;

   gpio_grp_irq_agg #(.GROUP_SIZE(GS), .NUM_GROUPS(NG), .WORD_W(WW), .EOI_POS(EP))
   u_gpio_grp_irq_agg (
      .clk(clk), .rst_n(rst_n), .pin_int_sts(int_v), .pin_wake_sts(wake_v),
      .ctl_wr_en(wr_en), .ctl_wr_data(wr_data), .ctl_rd_data(rd_data),
      .summary_lo(s_lo), .summary_hi(s_hi), .irq_out(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic ctl_write(input logic [WW-1:0] d);
      wr_en = 1'b1; wr_data = d;
      tick();
      wr_en = 1'b0; wr_data = '0;
   endtask

   function automatic logic [2*WW-1:0] model(input logic [NP-1:0] a, input logic [NP-1:0] b);
      logic [2*WW-1:0] r = '0;
      for (int p = 0; p < NP; p++)
         if (a[p] | b[p]) r[p / GS] = 1'b1;
      return r;
   endfunction

   task automatic chk_summary(input string req);
      logic [2*WW-1:0] e = model(int_v, wake_v);
      chk(req, {24'h0, s_lo}, {24'h0, e[WW-1:0]});
      chk(req, {24'h0, s_hi}, {24'h0, e[2*WW-1:WW]});
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         report();
      end
   end

   initial begin
      repeat (3) tick();
      // R9: reset state
      chk("R9 lo", {24'h0, s_lo}, 0);
      chk("R9 hi", {24'h0, s_hi}, 0);
      chk("R9 ctl", {24'h0, rd_data}, 0);
      chk("R9 irq", {31'h0, irq}, 0);
      rst_n = 1'b1;
      tick();

      // R1/R4: pin 6 sets group 1, request one edge after summary
      int_v[6] = 1'b1;
      tick();
      chk("R1 group1", {24'h0, s_lo}, 32'h02);
      chk("R4 not yet", {31'h0, irq}, 0);
      tick();
      chk("R4 raise", {31'h0, irq}, 1);

      // R5: request sticks after sources clear
      int_v = '0;
      tick(); tick();
      chk("R1 cleared", {24'h0, s_lo}, 0);
      chk("R5 hold", {31'h0, irq}, 1);

      // R6/R8: EOI drops request, reads zero
      ctl_write(8'h20);
      chk("R6 drop", {31'h0, irq}, 0);
      chk("R8 eoi reads 0", {24'h0, rd_data}, 0);
      tick();
      chk("R7 no source no request", {31'h0, irq}, 0);

      // R2/R3: wake on pin 39 -> group 9 -> high word bit 1
      wake_v[39] = 1'b1;
      tick();
      chk("R3 hi", {24'h0, s_hi}, 32'h02);
      chk("R2 lo", {24'h0, s_lo}, 0);
      tick();
      chk("R4 raise wake", {31'h0, irq}, 1);
      ctl_write(8'h20);
      chk("R6 drop pending", {31'h0, irq}, 0);
      tick();
      chk("R7 re-request", {31'h0, irq}, 1);

      // R8: other bits stored; EOI bit masked
      ctl_write(8'hA5);
      chk("R8 store masked", {24'h0, rd_data}, 32'h85);
      chk("R6 eoi in pattern", {31'h0, irq}, 0);
      ctl_write(8'h5A);
      chk("R8 store plain", {24'h0, rd_data}, 32'h5A);
      chk("R6 plain write keeps irq", {31'h0, irq}, 1);
      ctl_write(8'hFF);
      chk("R8 store all", {24'h0, rd_data}, 32'hDF);
      ctl_write(8'h00);
      chk("R8 store none", {24'h0, rd_data}, 32'h00);

      // R1/R2/R3: single-pin sweep through both status inputs
      wake_v = '0;
      for (int p = 0; p < NP; p++) begin
         for (int src = 0; src < 2; src++) begin
            int_v = '0; wake_v = '0;
            if (src == 0) int_v[p] = 1'b1;
            else          wake_v[p] = 1'b1;
            tick();
            chk_summary(src == 0 ? "R1 sweep int" : "R2 sweep wake");
         end
      end

      // R1/R3: multi-pin patterns
      for (int k = 0; k < 24; k++) begin
         int_v  = (NP'(1) << (k % NP)) | (NP'(1) << (NP - 1 - (k % NP)));
         wake_v = NP'(1) << ((k * 7) % NP);
         if (k % 5 == 0) int_v = int_v | (NP'(15) << (GS * (k % NG)));
         tick();
         chk_summary("R3 pattern");
      end

      // R5/R6/R7: clear sources, EOI, then quiet line
      int_v = '0; wake_v = '0;
      tick();
      chk("R5 hold after sweep", {31'h0, irq}, 1);
      ctl_write(8'h20);
      tick();
      chk("R7 quiet after eoi", {31'h0, irq}, 0);
      chk_summary("R1 empty");

      done = 1;
      report();
   end
endmodule